// File: doc/BRIEF.md
# Cascaded CAM Device Select Decoder

This block sits in each device of a daisy chain of content-addressable memories. It decides, for each of four bus cycle types, whether its own device takes part: command write, data write, command read and data read. The decision uses three inputs. The first is a 16-bit select value compared against the device's own page address, where an all-ones select value addresses every device at once. The second is a standard or enhanced mode bit. The third is a set of active-low cascade flags that describe where this device sits in the chain.

A small set of instruction classes overrides the plain decode. A write to the select register reaches every device. A page-address write and the set-full instruction reach only the first device that still has free space. A move into the next free location is blocked in a device that is full or not yet first in line. A status read that follows a next-free query is answered only by the device holding the first empty location. In enhanced mode, a broadcast read is answered only by the highest-priority matching device. The four enables are registered, so they appear one clock after their inputs.

Top module: `cam_dev_select`

## Requirements
- R1: While `rst_n` is low all four enables are 0; an asynchronous assertion of `rst_n` clears them without waiting for a clock edge.
- R2: With `op_i`=0 (plain) in standard mode and `dev_sel_i`=FFFFh, command write and data write are 1 and both reads are 0, even when `page_addr_i` is also FFFFh.
- R3: With `op_i`=0 and `dev_sel_i` equal to `page_addr_i` (not FFFFh), all four enables are 1 in either mode.
- R4: With `op_i`=0 and `dev_sel_i` neither FFFFh nor equal to `page_addr_i`, all four enables are 0.
- R5: In enhanced mode (`enh_mode_i`=1) with `dev_sel_i`=FFFFh and `op_i`=0, both writes are 1. Both reads are 1 only when `match_in_n_i`=1, `match_n_i`=0 and `mm_en_i`=1; otherwise both reads are 0.
- R6: With `mm_en_i`=0 the internal match is treated as inactive, so an enhanced-mode broadcast gives reads of 0 whatever `match_n_i` is.
- R7: With `op_i`=1 (select-register write), command write is 1 in every device regardless of addressing and flags; the other three enables follow the plain decode.
- R8: With `op_i`=2 (page-address write) or `op_i`=3 (set full), command write is 1 exactly when `full_in_n_i`=0 and `full_n_i`=1, regardless of addressing; the other enables follow the plain decode.
- R9: With `op_i`=4 (move to next free), command write is the plain-decode value ANDed with (`full_in_n_i`=0 and `full_n_i`=1); the other enables follow the plain decode.
- R10: With `op_i`=5 (status read after next-free query), command read is 1 exactly when the device is addressed (broadcast or page hit) and `full_in_n_i`=0 and `full_n_i`=1; the other enables follow the plain decode.
- R11: Each enable reflects the inputs sampled at the previous rising clock edge and does not change between edges.
- R12: The unused codes `op_i`=6 and `op_i`=7 decode exactly as `op_i`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_sel_i | input | 16 | Device-select value; FFFFh broadcasts |
| page_addr_i | input | 16 | This device's page address |
| enh_mode_i | input | 1 | 1 = enhanced mode, 0 = standard |
| op_i | input | 3 | Instruction class (0 plain, 1 select write, 2 page write, 3 set full, 4 move next free, 5 status after next-free query) |
| full_in_n_i | input | 1 | Full-in from the previous device, low = all devices above are full |
| full_n_i | input | 1 | Own full flag, low = this device is full |
| match_n_i | input | 1 | Own match flag, low = match found here |
| match_in_n_i | input | 1 | Match-in from above, low = a higher device matched |
| mm_en_i | input | 1 | Multiple-match reporting enable |
| cmd_wr_en_o | output | 1 | Registered command-write enable |
| data_wr_en_o | output | 1 | Registered data-write enable |
| cmd_rd_en_o | output | 1 | Registered command-read enable |
| data_rd_en_o | output | 1 | Registered data-read enable |

## Verification
Three addressing patterns are applied in both modes: broadcast, page hit and page miss. Comparing them shows whether the broadcast value, the page comparison and the mode gate of the reads are each decoded on their own. Under enhanced broadcast, the match flag, the match-in flag and the multiple-match enable are each turned off in turn; this shows that every one of them gates the read enables. Each exception class is run with the device first-free and then not first-free, and in addressed and unaddressed positions; this separates the override from the plain decode. Broadcast with a page address of FFFFh, the unused op codes, the one-clock delay and an asynchronous reset in mid-run cover the remaining boundaries.

// File: rtl/cam_sel_pkg.sv
package cam_sel_pkg;

  typedef enum logic [2:0] {
    OP_PLAIN     = 3'd0,
    OP_SET_SEL   = 3'd1,
    OP_SET_PAGE  = 3'd2,
    OP_MARK_FULL = 3'd3,
    OP_MOVE_NEXT = 3'd4,
    OP_STAT_NEXT = 3'd5,
    OP_RSVD6     = 3'd6,
    OP_RSVD7     = 3'd7
  } op_e;

  typedef struct packed {
    logic cmd_wr;
    logic data_wr;
    logic cmd_rd;
    logic data_rd;
  } en_t;

endpackage

// File: rtl/cam_sel_addr.sv
module cam_sel_addr #(
  parameter int SEL_W = 16
) (
  input  logic [SEL_W-1:0] dev_sel,
  input  logic [SEL_W-1:0] page_addr,
  output logic             bcast,
  output logic             page_hit
);
  localparam logic [SEL_W-1:0] BCAST_VAL = {SEL_W{1'b1}};

  always_comb begin
    bcast    = (dev_sel == BCAST_VAL);
    // broadcast takes precedence over an all-ones page address
    page_hit = !bcast && (dev_sel == page_addr);
  end
endmodule

// File: rtl/cam_sel_chain.sv
module cam_sel_chain (
  input  logic full_in_n,
  input  logic full_n,
  input  logic match_n,
  input  logic match_in_n,
  input  logic mm_en,
  output logic first_free,
  output logic hp_match
);
  logic ma_int_n;

  always_comb begin
    // all devices above are full and this one is not
    first_free = !full_in_n && full_n;
    // disabled multiple-match reporting parks the internal match inactive
    ma_int_n   = mm_en ? match_n : 1'b1;
    hp_match   = !ma_int_n && match_in_n;
  end
endmodule

// File: rtl/cam_sel_resp.sv
module cam_sel_resp
  import cam_sel_pkg::*;
(
  input  logic  bcast,
  input  logic  page_hit,
  input  logic  enh_mode,
  input  logic  first_free,
  input  logic  hp_match,
  input  op_e   op,
  output en_t   en_nxt
);
  logic addressed;
  logic rd_ok;
  en_t  base;

  always_comb begin
    addressed    = bcast || page_hit;
    rd_ok        = page_hit || (bcast && enh_mode && hp_match);
    base.cmd_wr  = addressed;
    base.data_wr = addressed;
    base.cmd_rd  = rd_ok;
    base.data_rd = rd_ok;

    en_nxt = base;
    unique case (op)
      OP_SET_SEL:   en_nxt.cmd_wr = 1'b1;
      OP_SET_PAGE,
      OP_MARK_FULL: en_nxt.cmd_wr = first_free;
      OP_MOVE_NEXT: en_nxt.cmd_wr = base.cmd_wr && first_free;
      OP_STAT_NEXT: en_nxt.cmd_rd = addressed && first_free;
      default:      en_nxt = base;
    endcase
  end
endmodule

// File: rtl/cam_dev_select.sv
module cam_dev_select
  import cam_sel_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] dev_sel_i,
  input  logic [SEL_W-1:0] page_addr_i,
  input  logic             enh_mode_i,
  input  logic [2:0]       op_i,
  input  logic             full_in_n_i,
  input  logic             full_n_i,
  input  logic             match_n_i,
  input  logic             match_in_n_i,
  input  logic             mm_en_i,
  output logic             cmd_wr_en_o,
  output logic             data_wr_en_o,
  output logic             cmd_rd_en_o,
  output logic             data_rd_en_o
);
  localparam logic [SEL_W-1:0] ALL_ONES = {SEL_W{1'b1}};

  logic bcast, page_hit, first_free, hp_match;
  en_t  en_nxt, en_q;
  op_e  op;

  assign op = op_e'(op_i);

  cam_sel_addr #(.SEL_W(SEL_W)) addr_i (
    .dev_sel   (dev_sel_i),
    .page_addr (page_addr_i),
    .bcast     (bcast),
    .page_hit  (page_hit)
  );

  cam_sel_chain chain_i (
    .full_in_n  (full_in_n_i),
    .full_n     (full_n_i),
    .match_n    (match_n_i),
    .match_in_n (match_in_n_i),
    .mm_en      (mm_en_i),
    .first_free (first_free),
    .hp_match   (hp_match)
  );

  cam_sel_resp resp_i (
    .bcast      (bcast),
    .page_hit   (page_hit),
    .enh_mode   (enh_mode_i),
    .first_free (first_free),
    .hp_match   (hp_match),
    .op         (op),
    .en_nxt     (en_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_nxt;
  end

  assign cmd_wr_en_o  = en_q.cmd_wr;
  assign data_wr_en_o = en_q.data_wr;
  assign cmd_rd_en_o  = en_q.cmd_rd;
  assign data_rd_en_o = en_q.data_rd;

  assert_std_bcast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!enh_mode_i && dev_sel_i == ALL_ONES && op_i == 3'd0)
    |=> (cmd_wr_en_o && data_wr_en_o && !cmd_rd_en_o && !data_rd_en_o));

  assert_miss_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_sel_i != ALL_ONES && dev_sel_i != page_addr_i && op_i == 3'd0)
    |=> !(cmd_wr_en_o || data_wr_en_o || cmd_rd_en_o || data_rd_en_o));

  assert_mm_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_mode_i && !mm_en_i && dev_sel_i == ALL_ONES && op_i == 3'd0)
    |=> (!data_rd_en_o && !cmd_rd_en_o));

  assert_sel_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd1) |=> cmd_wr_en_o);

  assert_page_write_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd2 && (full_in_n_i || !full_n_i)) |=> !cmd_wr_en_o);

endmodule

// File: tb/cam_dev_select_tb_top.sv
module cam_dev_select_tb_top;
  localparam int CLK_NS = 20;
  localparam int NVEC   = 24;
  localparam logic [15:0] PAGE = 16'h0123;

  // op[15:13] enh[12] mm[11] fin[10] ff[9] m[8] mi[7] sel[6:5] pad[4] exp[3:0]
  // sel: 0 broadcast, 1 page hit, 2 miss; exp = {cmd_wr,data_wr,cmd_rd,data_rd}
  localparam logic [15:0] VEC [0:NVEC-1] = '{
    16'b000_0_1_0_1_1_1_00_0_1100,
    16'b000_0_1_0_1_1_1_01_0_1111,
    16'b000_0_1_0_1_1_1_10_0_0000,
    16'b000_1_1_0_1_0_1_00_0_1111,
    16'b000_1_1_0_1_0_0_00_0_1100,
    16'b000_1_1_0_1_1_1_00_0_1100,
    16'b000_1_0_0_1_0_1_00_0_1100,
    16'b000_1_1_0_1_1_1_01_0_1111,
    16'b000_1_1_0_1_1_1_10_0_0000,
    16'b001_0_1_1_0_1_1_10_0_1000,
    16'b010_0_1_0_1_1_1_10_0_1000,
    16'b010_0_1_1_1_1_1_01_0_0111,
    16'b011_0_1_0_0_1_1_01_0_0111,
    16'b011_0_1_0_1_1_1_00_0_1100,
    16'b100_0_1_0_1_1_1_01_0_1111,
    16'b100_0_1_1_1_1_1_01_0_0111,
    16'b100_0_1_0_0_1_1_00_0_0100,
    16'b101_0_1_0_1_1_1_00_0_1110,
    16'b101_0_1_1_1_1_1_00_0_1100,
    16'b101_0_1_0_1_1_1_10_0_0000,
    16'b101_0_1_0_0_1_1_01_0_1101,
    16'b110_0_1_0_1_1_1_10_0_0000,
    16'b111_0_1_0_1_1_1_01_0_1111,
    16'b101_1_1_0_1_0_1_00_0_1111
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] dev_sel, page_addr;
  logic        enh, mm_en, fin_n, ff_n, m_n, mi_n;
  logic [2:0]  op;
  logic        cw, dw, cr, dr;
  int          n_chk = 0;
  int          n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  cam_dev_select dut_i (
    .clk(clk), .rst_n(rst_n), .dev_sel_i(dev_sel), .page_addr_i(page_addr),
    .enh_mode_i(enh), .op_i(op), .full_in_n_i(fin_n), .full_n_i(ff_n),
    .match_n_i(m_n), .match_in_n_i(mi_n), .mm_en_i(mm_en),
    .cmd_wr_en_o(cw), .data_wr_en_o(dw), .cmd_rd_en_o(cr), .data_rd_en_o(dr)
  );

  task automatic check(input string req, input logic [3:0] exp);
    n_chk++;
    if ({cw, dw, cr, dr} !== exp) begin
      n_fail++;
      $display("FAIL %s actual %b expected %b", req, {cw, dw, cr, dr}, exp);
    end
  endtask

  function automatic string tag_of(input logic [15:0] v);
    case (v[15:13])
      3'd1: return "R7";
      3'd2, 3'd3: return "R8";
      3'd4: return "R9";
      3'd5: return "R10";
      3'd6, 3'd7: return "R12";
      default: begin
        if (v[6:5] == 2'd1) return "R3";
        if (v[6:5] == 2'd2) return "R4";
        if (v[12] && !v[11]) return "R6";
        if (v[12]) return "R5";
        return "R2";
      end
    endcase
  endfunction

  task automatic drive(input logic [15:0] v);
    op    = v[15:13];
    enh   = v[12];
    mm_en = v[11];
    fin_n = v[10];
    ff_n  = v[9];
    m_n   = v[8];
    mi_n  = v[7];
    page_addr = PAGE;
    case (v[6:5])
      2'd0:    dev_sel = 16'hFFFF;
      2'd1:    dev_sel = PAGE;
      default: dev_sel = PAGE + 16'd1;
    endcase
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_fail++;
    $display("FAIL watchdog actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(VEC[1]);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 4'b0000);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check(tag_of(VEC[i]), VEC[i][3:0]);
    end

    // broadcast wins over an all-ones page address
    drive(VEC[0]);
    page_addr = 16'hFFFF;
    @(negedge clk);
    check("R2", 4'b1100);

    // page hit at address zero, enhanced mode
    drive(VEC[7]);
    page_addr = 16'h0000;
    dev_sel   = 16'h0000;
    @(negedge clk);
    check("R3", 4'b1111);

    // one-clock latency: new inputs do not show before the edge
    drive(VEC[2]);
    #(CLK_NS/4);
    check("R11", 4'b1111);
    @(negedge clk);
    check("R11", 4'b0000);

    // asynchronous reset between edges
    drive(VEC[1]);
    @(negedge clk);
    check("R3", 4'b1111);
    #(CLK_NS/4);
    rst_n = 1'b0;
    #1;
    check("R1", 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3", 4'b1111);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule